// File: doc/BRIEF.md
# Two-Port Packet Switch with Shared Event Counter

This block moves packets from two input queues to two output queues. Each packet has a 32-bit payload, a one-bit destination and a one-bit "interesting" flag. Both input paths work in parallel. In a cycle, a path takes the packet at the head of its input queue and writes it into output queue 0 when the destination bit is 0, or into output queue 1 when the bit is 1. If the flag is set, the path also adds one to a shared 16-bit counter. Upstream logic writes packets in with a valid/ready handshake, and downstream logic drains each output queue with its own valid/ready handshake. The counter value is always visible on a read port.

A transfer is all-or-nothing and has no staging register. A path moves its packet only if its input queue holds a packet, its target output queue is not full, and it holds the grant for that output. An interesting packet also needs the grant for the counter. If a path cannot get everything it needs, its packet stays at the head of its input queue and the counter does not change for it. Path 0 wins every collision. Grants go only to paths that can complete their transfer, so a path 0 packet that is itself stalled never holds back path 1.

Top module: `pkt_switch2`

## Requirements
- R1: After a synchronous active-low reset, both outputs show no valid packet, both inputs show ready, and the count reads 0.
- R2: A packet with destination bit 0 leaves on output 0, and a packet with destination bit 1 leaves on output 1. Payload and flag are unchanged, and packets from one input to one output keep their order.
- R3: Each transferred packet whose interesting flag is 1 adds exactly one to the count. Packets with the flag at 0 leave the count unchanged.
- R4: An output queue accepts at most one packet per cycle. When both paths target the same output, path 0's packet is written first and path 1's packet follows one cycle later.
- R5: The count rises by at most one per cycle. When both head packets are interesting, path 0 moves and path 1 waits one cycle, even when they target different outputs.
- R6: Two head packets with different destinations, of which at most one is interesting, both move in the same cycle.
- R7: A packet whose target output queue is full stays in its input queue and does not change the count. The other path still moves packets to its own non-full output.
- R8: Every queue holds 4 packets. An input shows not-ready while its queue is full, and a push offered while not ready is ignored.
- R9: The count is 16 bits wide and wraps from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in0_valid | input | 1 | Input 0 offers a packet |
| in0_ready | output | 1 | Input 0 queue has room |
| in0_data | input | 32 | Input 0 payload |
| in0_dest | input | 1 | Input 0 destination bit |
| in0_mark | input | 1 | Input 0 interesting flag |
| in1_valid | input | 1 | Input 1 offers a packet |
| in1_ready | output | 1 | Input 1 queue has room |
| in1_data | input | 32 | Input 1 payload |
| in1_dest | input | 1 | Input 1 destination bit |
| in1_mark | input | 1 | Input 1 interesting flag |
| out0_valid | output | 1 | Output 0 has a packet |
| out0_ready | input | 1 | Consumer takes output 0 packet |
| out0_data | output | 32 | Output 0 payload |
| out0_dest | output | 1 | Output 0 destination bit |
| out0_mark | output | 1 | Output 0 interesting flag |
| out1_valid | output | 1 | Output 1 has a packet |
| out1_ready | input | 1 | Consumer takes output 1 packet |
| out1_data | output | 32 | Output 1 payload |
| out1_dest | output | 1 | Output 1 destination bit |
| out1_mark | output | 1 | Output 1 interesting flag |
| pkt_count | output | 16 | Count of transferred interesting packets |

## Verification
The first test sends single packets covering all four combinations of destination bit and flag, which confirms routing and counting for one packet at a time. The bench then pushes pairs of packets in the same cycle while both outputs are held blocked. One pair targets different outputs with one flag set, another targets the same output, and another sets both flags. Each pair isolates a different conflict: none, an output collision, or a counter collision. Reading which output queues have filled one and two cycles later shows whether the switch moved both packets together or serialised them with path 0 first. Next, an output is held full to test back-pressure: the other path must keep moving, and the input queue must fill and refuse one more push. Last, a long stream of interesting packets drives the count through its wrap point.

// File: rtl/sw2_pkg.sv
// Shared packet type and helpers for the two-port switch.
// Assumes one destination bit selects one of exactly two outputs.
package sw2_pkg;
    parameter int SW2_PAYLOAD_W = 32;

    typedef struct packed {
        logic                     mark;
        logic                     dest;
        logic [SW2_PAYLOAD_W-1:0] payload;
    } sw2_pkt_t;

    localparam int SW2_PKT_W = $bits(sw2_pkt_t);

    // True when a head packet with this destination bit is routed to output j.
    function automatic logic sw2_routes_to(input logic dest, input int j);
        return (j == 0) ? (dest == 1'b0) : (dest == 1'b1);
    endfunction
endpackage

// File: rtl/sw2_fifo.sv
// Synchronous FIFO with registered full and empty flags.
// Assumes push is ignored when full and pop is ignored when empty;
// simultaneous push and pop are allowed at any fill level.
module sw2_fifo #(
    parameter int W     = 34,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill, fill_next;
    logic          full_q, empty_q;
    logic          do_push, do_pop;

    assign do_push = push && !full_q;
    assign do_pop  = pop && !empty_q;

    // Next fill level from accepted operations.
    always_comb begin
        fill_next = fill + CW'(do_push) - CW'(do_pop);
    end

    // Storage write; no reset needed on data.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointers, fill level and registered flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            fill    <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            fill    <= fill_next;
            full_q  <= (fill_next == CW'(DEPTH));
            empty_q <= (fill_next == '0);
        end
    end

    assign dout  = mem[rd_ptr];
    assign full  = full_q;
    assign empty = empty_q;
endmodule

// File: rtl/sw2_arbiter.sv
// Grant logic for the two switch paths. A path is eligible when it has a
// head packet and its target output is not full. Path 0 always moves when
// eligible; path 1 is blocked only by an eligible path 0 that uses the same
// output or that also needs the counter.
// Assumes exactly two paths and two outputs.
module sw2_arbiter (
    input  logic [1:0] have_pkt,
    input  logic [1:0] dest,
    input  logic [1:0] mark,
    input  logic [1:0] out_full,
    output logic [1:0] grant
);
    logic [1:0] eligible;
    logic       out_clash, cnt_clash;

    // Per-path readiness: a packet present and room at its target.
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            eligible[i] = have_pkt[i] && !out_full[dest[i]];
        end
    end

    // Fixed priority resolution of output and counter conflicts.
    always_comb begin
        out_clash = (dest[0] == dest[1]);
        cnt_clash = mark[0] && mark[1];
        grant[0]  = eligible[0];
        grant[1]  = eligible[1] && !(eligible[0] && (out_clash || cnt_clash));
    end
endmodule

// File: rtl/sw2_counter.sv
// Wrapping event counter with a single increment strobe.
// Assumes the caller guarantees at most one increment per cycle.
module sw2_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    // Count up on each strobe; natural overflow wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)   value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/pkt_switch2.sv
// Two-input, two-output packet switch with a shared counter of packets
// that carry the interesting flag. Each input path moves its head packet
// to the output chosen by its destination bit only if the whole transfer,
// including the counter update, can complete in that cycle.
// Assumes consumers follow valid/ready: a packet is taken when both are high.
module pkt_switch2
    import sw2_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in0_valid,
    output logic                     in0_ready,
    input  logic [SW2_PAYLOAD_W-1:0] in0_data,
    input  logic                     in0_dest,
    input  logic                     in0_mark,
    input  logic                     in1_valid,
    output logic                     in1_ready,
    input  logic [SW2_PAYLOAD_W-1:0] in1_data,
    input  logic                     in1_dest,
    input  logic                     in1_mark,
    output logic                     out0_valid,
    input  logic                     out0_ready,
    output logic [SW2_PAYLOAD_W-1:0] out0_data,
    output logic                     out0_dest,
    output logic                     out0_mark,
    output logic                     out1_valid,
    input  logic                     out1_ready,
    output logic [SW2_PAYLOAD_W-1:0] out1_data,
    output logic                     out1_dest,
    output logic                     out1_mark,
    output logic [CNT_W-1:0]         pkt_count
);
    localparam int NPORT = 2;

    sw2_pkt_t             in_pkt  [NPORT];
    sw2_pkt_t             head    [NPORT];
    sw2_pkt_t             out_din [NPORT];
    sw2_pkt_t             out_head[NPORT];
    logic [NPORT-1:0]     in_push, in_full, in_empty, have_pkt;
    logic [NPORT-1:0]     hd_dest, hd_mark, grant;
    logic [NPORT-1:0]     out_push, out_pop, out_full, out_empty, out_rdy;
    logic [NPORT-1:0]     sel [NPORT];
    logic                 cnt_inc;

    // Gather the input-side pins into packet records.
    always_comb begin
        in_pkt[0] = '{mark: in0_mark, dest: in0_dest, payload: in0_data};
        in_pkt[1] = '{mark: in1_mark, dest: in1_dest, payload: in1_data};
        in_push   = {in1_valid, in0_valid};
        out_rdy   = {out1_ready, out0_ready};
    end

    // One input queue per path.
    for (genvar i = 0; i < NPORT; i++) begin : g_in
        sw2_fifo #(.W(SW2_PKT_W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (in_push[i]),
            .din   (in_pkt[i]),
            .pop   (grant[i]),
            .dout  (head[i]),
            .full  (in_full[i]),
            .empty (in_empty[i])
        );
        assign hd_dest[i]  = head[i].dest;
        assign hd_mark[i]  = head[i].mark;
        assign have_pkt[i] = !in_empty[i];
    end

    sw2_arbiter u_arb (
        .have_pkt (have_pkt),
        .dest     (hd_dest),
        .mark     (hd_mark),
        .out_full (out_full),
        .grant    (grant)
    );

    // Route granted head packets onto the output queues.
    always_comb begin
        for (int j = 0; j < NPORT; j++) begin
            for (int i = 0; i < NPORT; i++) begin
                sel[j][i] = grant[i] && sw2_routes_to(hd_dest[i], j);
            end
            out_push[j] = |sel[j];
            out_din[j]  = sel[j][0] ? head[0] : head[1];
            out_pop[j]  = !out_empty[j] && out_rdy[j];
        end
    end

    // One output queue per destination.
    for (genvar j = 0; j < NPORT; j++) begin : g_out
        sw2_fifo #(.W(SW2_PKT_W), .DEPTH(DEPTH)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (out_push[j]),
            .din   (out_din[j]),
            .pop   (out_pop[j]),
            .dout  (out_head[j]),
            .full  (out_full[j]),
            .empty (out_empty[j])
        );
    end

    // Counter strobe from any granted interesting packet.
    assign cnt_inc = |(grant & hd_mark);

    sw2_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (cnt_inc),
        .value (pkt_count)
    );

    // Drive the port pins from the queue flags and heads.
    always_comb begin
        in0_ready  = !in_full[0];
        in1_ready  = !in_full[1];
        out0_valid = !out_empty[0];
        out0_data  = out_head[0].payload;
        out0_dest  = out_head[0].dest;
        out0_mark  = out_head[0].mark;
        out1_valid = !out_empty[1];
        out1_data  = out_head[1].payload;
        out1_dest  = out_head[1].dest;
        out1_mark  = out_head[1].mark;
    end
endmodule

// File: rtl/sw2_checker.sv
// Property checker for the two-port switch, attached by bind.
// Assumes the grant, head and flag nets of the switch are visible by name.
module sw2_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       grant,
    input logic [1:0]       hd_dest,
    input logic [1:0]       hd_mark,
    input logic [1:0]       in_empty,
    input logic [1:0]       out_full,
    input logic [CNT_W-1:0] pkt_count
);
    logic past_ok;

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_count_cleared: assert property (@(posedge clk)
        !rst_n |=> pkt_count == '0);

    a_r2_move_needs_packet: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & in_empty) == 2'b00);

    a_r7_room_path0: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |-> !out_full[hd_dest[0]]);

    a_r7_room_path1: assert property (@(posedge clk) disable iff (!rst_n)
        grant[1] |-> !out_full[hd_dest[1]]);

    a_r4_one_write_per_output: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b11) |-> (hd_dest[0] != hd_dest[1]));

    a_r5_one_count_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == 2'b11) |-> !(hd_mark[0] && hd_mark[1]));

    a_r6_parallel_move: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_empty == 2'b00) && (hd_dest[0] != hd_dest[1]) &&
         !(hd_mark[0] && hd_mark[1]) && (out_full == 2'b00)) |-> (grant == 2'b11));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (pkt_count == $past(pkt_count) ||
                     pkt_count == $past(pkt_count) + 1'b1));

    a_r3_count_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && pkt_count != $past(pkt_count)) |-> $past(|(grant & hd_mark)));
endmodule

bind pkt_switch2 sw2_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .hd_dest   (hd_dest),
    .hd_mark   (hd_mark),
    .in_empty  (in_empty),
    .out_full  (out_full),
    .pkt_count (pkt_count)
);

// File: tb/sim_pkt_switch2.sv
`timescale 1ns/1ps
module sim_pkt_switch2;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in0_valid = 0, in1_valid = 0;
    logic        in0_ready, in1_ready;
    logic [31:0] in0_data = '0, in1_data = '0;
    logic        in0_dest = 0, in1_dest = 0, in0_mark = 0, in1_mark = 0;
    logic        out0_valid, out1_valid;
    logic        out0_ready = 0, out1_ready = 0;
    logic [31:0] out0_data, out1_data;
    logic        out0_dest, out1_dest, out0_mark, out1_mark;
    logic [15:0] pkt_count;

    int          tests = 0;
    int          fails = 0;
    logic [15:0] exp_cnt = '0;
    int          seq = 0;
    logic [32:0] q00[$], q01[$], q10[$], q11[$];   // index: output, source

    always #10 clk = ~clk;   // 50 MHz

    pkt_switch2 u0 (.*);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #5;
    endtask

    // Record an accepted packet in the scoreboard; payload bit 31 is the source.
    task automatic record(input int src, input logic dest, input logic mark, input logic [31:0] d);
        case ({dest, src[0]})
            2'b00: q00.push_back({mark, d});
            2'b01: q01.push_back({mark, d});
            2'b10: q10.push_back({mark, d});
            default: q11.push_back({mark, d});
        endcase
        if (mark) exp_cnt = exp_cnt + 1'b1;
    endtask

    function automatic logic [31:0] mkdata(input int src);
        seq++;
        return {src[0], 31'(seq)};
    endfunction

    task automatic drive(input int src, input logic v, input logic dest, input logic mark, input logic [31:0] d);
        if (src == 0) begin in0_valid = v; in0_dest = dest; in0_mark = mark; in0_data = d; end
        else          begin in1_valid = v; in1_dest = dest; in1_mark = mark; in1_data = d; end
    endtask

    // Offer one packet; returns 1 if accepted within that single cycle.
    task automatic attempt(input int src, input logic dest, input logic mark, output bit took);
        logic [31:0] d;
        d = mkdata(src);
        drive(src, 1'b1, dest, mark, d);
        @(negedge clk);
        took = (src == 0) ? in0_ready : in1_ready;
        if (took) record(src, dest, mark, d);
        tick();
        drive(src, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic push1(input int src, input logic dest, input logic mark);
        bit took;
        took = 0;
        while (!took) attempt(src, dest, mark, took);
    endtask

    // Offer a packet on both inputs in the same cycle; both must be ready.
    task automatic push_pair(input logic d0, input logic m0, input logic d1, input logic m1);
        logic [31:0] a, b;
        a = mkdata(0); b = mkdata(1);
        drive(0, 1'b1, d0, m0, a);
        drive(1, 1'b1, d1, m1, b);
        @(negedge clk);
        check(in0_ready && in1_ready, "R8 pair inputs ready", {in1_ready, in0_ready}, 2'b11);
        record(0, d0, m0, a);
        record(1, d1, m1, b);
        tick();
        drive(0, 1'b0, 1'b0, 1'b0, '0);
        drive(1, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic sb_pop(input int o, input logic [31:0] d, input logic dest, input logic mark);
        logic [32:0] e;
        bit          have;
        have = 0;
        case ({o[0], d[31]})
            2'b00: if (q00.size() > 0) begin e = q00.pop_front(); have = 1; end
            2'b01: if (q01.size() > 0) begin e = q01.pop_front(); have = 1; end
            2'b10: if (q10.size() > 0) begin e = q10.pop_front(); have = 1; end
            default: if (q11.size() > 0) begin e = q11.pop_front(); have = 1; end
        endcase
        if (!have) check(1'b0, "R2 unexpected packet", d, 0);
        else check(e == {mark, d} && dest == o[0], "R2 route/order/content", {dest, mark, d}, {o[0], e});
    endtask

    // Monitor: a pop happens at the next edge when valid and ready are both high.
    always @(negedge clk) begin
        if (rst_n) begin
            if (out0_valid && out0_ready) sb_pop(0, out0_data, out0_dest, out0_mark);
            if (out1_valid && out1_ready) sb_pop(1, out1_data, out1_dest, out1_mark);
        end
    end

    function automatic int pending();
        return q00.size() + q01.size() + q10.size() + q11.size();
    endfunction

    // Watchdog.
    initial begin
        #(20 * 190000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] p0, p1;
        logic [15:0] c;
        int          acc, n;
        bit          took;

        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out0_valid && !out1_valid, "R1 outputs empty", {out1_valid, out0_valid}, 0);
        check(in0_ready && in1_ready, "R1 inputs ready", {in1_ready, in0_ready}, 2'b11);
        check(pkt_count == 0, "R1 count zero", pkt_count, 0);
        tick();

        // R2/R3: one packet per destination/flag combination.
        out0_ready = 1; out1_ready = 1;
        push1(0, 0, 0); push1(0, 1, 1); push1(1, 0, 1); push1(1, 1, 0);
        wait_cycles(8);
        check(pending() == 0, "R2 all delivered", pending(), 0);
        check(pkt_count == 2, "R3 two flagged counted", pkt_count, 2);

        // R6: different outputs, one flag -> both move together.
        out0_ready = 0; out1_ready = 0;
        c = pkt_count;
        push_pair(0, 1, 1, 0);
        @(negedge clk); @(negedge clk);
        check(out0_valid && out1_valid, "R6 both moved same cycle", {out1_valid, out0_valid}, 2'b11);
        check(pkt_count == c + 1, "R6 count one", pkt_count, c + 1);
        tick();
        out0_ready = 1; out1_ready = 1;
        wait_cycles(6);

        // R4: same output collision, path 0 first.
        out0_ready = 0; out1_ready = 0;
        p0 = {1'b0, 31'(seq + 1)}; p1 = {1'b1, 31'(seq + 2)};
        push_pair(0, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        check(out0_valid && !out1_valid, "R4 one write to output 0", {out1_valid, out0_valid}, 2'b01);
        check(out0_data == p0, "R4 path 0 wins", out0_data, p0);
        tick();
        out0_ready = 1;
        @(negedge clk);
        check(out0_data == p0, "R4 first out is path 0", out0_data, p0);
        @(negedge clk);
        check(out0_valid && out0_data == p1, "R4 second out is path 1", out0_data, p1);
        tick();
        out1_ready = 1;
        wait_cycles(6);

        // R5: both flagged, different outputs -> serialised.
        out0_ready = 0; out1_ready = 0;
        c = pkt_count;
        push_pair(0, 1, 1, 1);
        @(negedge clk); @(negedge clk);
        check(out0_valid && !out1_valid, "R5 path 0 only", {out1_valid, out0_valid}, 2'b01);
        check(pkt_count == c + 1, "R5 count plus one", pkt_count, c + 1);
        @(negedge clk);
        check(out1_valid, "R5 path 1 next cycle", out1_valid, 1);
        check(pkt_count == c + 2, "R5 count plus two", pkt_count, c + 2);
        tick();
        out0_ready = 1; out1_ready = 1;
        wait_cycles(6);

        // R7/R8: output 0 held full.
        out0_ready = 0; out1_ready = 0;
        for (int k = 0; k < 4; k++) push1(0, 0, 0);
        wait_cycles(2);
        c = pkt_count;
        push1(0, 0, 1);
        wait_cycles(3);
        check(pkt_count == c, "R7 blocked packet not counted", pkt_count, c);
        push1(1, 1, 0);
        @(negedge clk); @(negedge clk);
        check(out1_valid, "R7 other path proceeds", out1_valid, 1);
        tick();
        acc = 0;
        for (int k = 0; k < 5; k++) begin
            attempt(0, 0, 0, took);
            if (took) acc++;
        end
        check(acc == 3, "R8 input queue holds 4", acc, 3);
        @(negedge clk);
        check(!in0_ready, "R8 full input not ready", in0_ready, 0);
        tick();
        out0_ready = 1; out1_ready = 1;
        wait_cycles(20);
        check(pending() == 0 && !out0_valid && !out1_valid, "R8 refused push ignored", pending(), 0);
        check(pkt_count == c + 1, "R7 counted after release", pkt_count, c + 1);

        // R9: stream flagged packets through the wrap point.
        n = 65535 - int'(pkt_count);
        for (int pass = 0; pass < 2; pass++) begin
            int done_n;
            done_n = 0;
            while (done_n < n) begin
                logic [31:0] d;
                logic        dd;
                d = mkdata(0);
                dd = d[0];
                drive(0, 1'b1, dd, 1'b1, d);
                @(negedge clk);
                if (in0_ready) begin record(0, dd, 1'b1, d); done_n++; end
                tick();
            end
            drive(0, 1'b0, 1'b0, 1'b0, '0);
            wait_cycles(8);
            if (pass == 0) begin
                check(pkt_count == 16'hFFFF, "R9 count at max", pkt_count, 16'hFFFF);
                n = 3;
            end else begin
                check(pkt_count == 16'h0002, "R9 count wrapped", pkt_count, 2);
            end
        end
        check(pkt_count == exp_cnt, "R3 total count", pkt_count, exp_cnt);
        check(pending() == 0, "R2 scoreboard drained", pending(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule